// File: doc/BRIEF.md
# Dual-Loop Digital Lock Detector with Frequency Monitor Output

This block runs on the reference oscillator clock and watches two phase-locked loops, an intermediate-frequency loop and a radio-frequency loop. For each loop it sees a reference pulse stream and a divided-VCO comparison pulse stream. On every comparison cycle it measures the phase error as the number of oscillator cycles between the rising edge of one stream and the rising edge of the other, whichever edge comes first. From these widths it keeps a locked or unlocked state per loop.

A single large error drops a loop out of lock at once. A loop only regains lock after a run of consecutive small errors. The two loop states are merged into one lock flag. A loop held in power save counts as locked in that merge. The same registered output pin can instead carry one of the four raw pulse streams, which is useful for probing dividers on the bench. The choice is made by a monitor enable and a two-bit source select.

Top module: `dual_lock_watch`

## Requirements
- R1: After reset both loops are unlocked, so with monitoring off and no loop in power save the output is low.
- R2: The phase error width is the count of oscillator cycles from the first rising edge of either stream to the rising edge of the other. Either stream may lead. Coincident edges give width 0. The count saturates at ERR_UNLOCK_MIN.
- R3: A single comparison cycle whose width is at least ERR_UNLOCK_MIN (default 4) makes that loop unlocked and clears its good-cycle run.
- R4: A loop becomes locked once GOOD_RUN (default 3) consecutive comparison cycles each have a width of at most ERR_LOCK_MAX (default 2). Fewer such cycles leave it unlocked.
- R5: A width strictly between ERR_LOCK_MAX and ERR_UNLOCK_MIN leaves the lock state unchanged but clears the good-cycle run.
- R6: The merged lock flag is high exactly when each loop is locked or has its power-save input high.
- R7: With mon_en_i low the output carries the merged lock flag. With mon_en_i high, tsel_i selects a raw stream: 2'b00 IF reference, 2'b01 RF reference, 2'b10 IF comparison, 2'b11 RF comparison. Here tsel_i[0] is the first test bit.
- R8: Two rising edges of the leading stream with no edge of the other stream between them count as a cycle slip, which is an error of width ERR_UNLOCK_MIN. A new measurement then starts from the second edge.
- R9: The output is registered. It reflects its inputs and lock states one oscillator clock after they are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference oscillator clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| ref_if_i | input | 1 | IF loop reference pulse stream |
| cmp_if_i | input | 1 | IF loop comparison pulse stream |
| ref_rf_i | input | 1 | RF loop reference pulse stream |
| cmp_rf_i | input | 1 | RF loop comparison pulse stream |
| save_if_i | input | 1 | IF loop in power save, treated as locked |
| save_rf_i | input | 1 | RF loop in power save, treated as locked |
| mon_en_i | input | 1 | 1 routes a raw stream to the output, 0 routes the lock flag |
| tsel_i | input | 2 | Raw stream select used when monitoring |
| mon_o | output | 1 | Registered lock flag or monitored stream |

## Verification
The bench builds the block with ERR_LOCK_MAX=2, ERR_UNLOCK_MIN=4 and GOOD_RUN=3. These values leave a width of 3 as a middle band that is neither good nor bad, so streak clearing without unlock can be observed. They also let a 20-cycle gap exercise counter saturation, and keep the three-cycle lock run short enough to build and break several times. Each loop is isolated by holding the other in power save, so the single output pin reveals one loop's state at a time.

// File: rtl/dual_lock_watch.sv
module dual_lock_watch #(
  parameter int ERR_LOCK_MAX   = 2,
  parameter int ERR_UNLOCK_MIN = 4,
  parameter int GOOD_RUN       = 3
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       ref_if_i,
  input  logic       cmp_if_i,
  input  logic       ref_rf_i,
  input  logic       cmp_rf_i,
  input  logic       save_if_i,
  input  logic       save_rf_i,
  input  logic       mon_en_i,
  input  logic [1:0] tsel_i,
  output logic       mon_o
);
  localparam int CW = $clog2(ERR_UNLOCK_MIN + 1);
  localparam int RW = $clog2(GOOD_RUN + 1);
  localparam logic [CW-1:0] W_BAD  = CW'(ERR_UNLOCK_MIN);
  localparam logic [CW-1:0] W_GOOD = CW'(ERR_LOCK_MAX);
  localparam logic [RW-1:0] RUN_N  = RW'(GOOD_RUN);

  logic [1:0] refv, cmpv, save_v, lk_v, ev_v;
  assign refv   = {ref_rf_i, ref_if_i};
  assign cmpv   = {cmp_rf_i, cmp_if_i};
  assign save_v = {save_rf_i, save_if_i};

  for (genvar k = 0; k < 2; k++) begin : g_loop
    logic          ref_d, cmp_d, pend, lead_c, lk, ev;
    logic [CW-1:0] cnt, w;
    logic [RW-1:0] run;
    logic          er, ec, closes, again;

    assign er     = refv[k] & ~ref_d;
    assign ec     = cmpv[k] & ~cmp_d;
    assign closes = pend & (lead_c ? er : ec);
    assign again  = pend & ~closes & (lead_c ? ec : er);

    always_comb begin
      ev = 1'b0;
      w  = '0;
      if (!pend && er && ec) begin
        ev = 1'b1;
      end else if (closes) begin
        ev = 1'b1;
        w  = cnt;
      end else if (again) begin
        ev = 1'b1;
        w  = W_BAD;
      end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
        ref_d  <= 1'b0;
        cmp_d  <= 1'b0;
        pend   <= 1'b0;
        lead_c <= 1'b0;
        cnt    <= '0;
      end else begin
        ref_d <= refv[k];
        cmp_d <= cmpv[k];
        if (!pend) begin
          if (er ^ ec) begin
            pend   <= 1'b1;
            lead_c <= ec;
            cnt    <= CW'(1);
          end
        end else if (closes) begin
          pend <= 1'b0;
        end else if (again) begin
          cnt <= CW'(1);
        end else if (cnt < W_BAD) begin
          cnt <= cnt + CW'(1);
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
        lk  <= 1'b0;
        run <= '0;
      end else if (ev) begin
        if (w >= W_BAD) begin
          lk  <= 1'b0;
          run <= '0;
        end else if (w <= W_GOOD) begin
          if (run >= RUN_N - RW'(1)) lk <= 1'b1;
          if (run < RUN_N) run <= run + RW'(1);
        end else begin
          run <= '0;
        end
      end
    end

    assign lk_v[k] = lk;
    assign ev_v[k] = ev;
  end

  logic lock_all, mon_sel;
  assign lock_all = &(lk_v | save_v);

  always_comb begin
    case (tsel_i)
      2'b00:   mon_sel = ref_if_i;
      2'b01:   mon_sel = ref_rf_i;
      2'b10:   mon_sel = cmp_if_i;
      default: mon_sel = cmp_rf_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) mon_o <= 1'b0;
    else          mon_o <= mon_en_i ? mon_sel : lock_all;
  end
endmodule

// File: rtl/dual_lock_watch_chk.sv
module dual_lock_watch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mon_en,
  input logic [1:0] tsel,
  input logic       ref_if,
  input logic       cmp_rf,
  input logic       save_if,
  input logic       save_rf,
  input logic [1:0] lk,
  input logic [1:0] ev,
  input logic       mon_o
);
  p_lock_rise_on_eval_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lk[0]) |-> $past(ev[0]));
  p_lock_fall_on_eval_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lk[1]) |-> $past(ev[1]));
  p_saved_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_en && save_if && save_rf) |=> mon_o);
  p_unlocked_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_en && !lk[0] && !save_if) |=> !mon_o);
  p_mon_ref_if_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en && tsel == 2'b00) |=> (mon_o == $past(ref_if)));
  p_mon_cmp_rf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en && tsel == 2'b11) |=> (mon_o == $past(cmp_rf)));
endmodule

bind dual_lock_watch dual_lock_watch_chk chk_i (
  .clk(clk_i), .rst_n(rst_n_i), .mon_en(mon_en_i), .tsel(tsel_i),
  .ref_if(ref_if_i), .cmp_rf(cmp_rf_i), .save_if(save_if_i),
  .save_rf(save_rf_i), .lk(lk_v), .ev(ev_v), .mon_o(mon_o)
);

// File: tb/dual_lock_watch_tb_top.sv
module dual_lock_watch_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_if = 0, cmp_if = 0, ref_rf = 0, cmp_rf = 0;
  logic save_if = 0, save_rf = 0, mon_en = 0;
  logic [1:0] tsel = 2'b00;
  logic mon_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_lock_watch #(.ERR_LOCK_MAX(2), .ERR_UNLOCK_MIN(4), .GOOD_RUN(3)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .ref_if_i(ref_if), .cmp_if_i(cmp_if),
    .ref_rf_i(ref_rf), .cmp_rf_i(cmp_rf), .save_if_i(save_if),
    .save_rf_i(save_rf), .mon_en_i(mon_en), .tsel_i(tsel), .mon_o(mon_o));

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: mon_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ref_if = 0; cmp_if = 0; ref_rf = 0; cmp_rf = 0;
    save_if = 0; save_rf = 0; mon_en = 0; tsel = 2'b00;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic drive(input int lp, input logic r, input logic c);
    if (lp == 0) begin ref_if = r; cmp_if = c; end
    else begin ref_rf = r; cmp_rf = c; end
  endtask

  task automatic pulse_pair(input int lp, input bit cfirst, input int gap);
    @(negedge clk);
    if (gap == 0) drive(lp, 1, 1); else drive(lp, !cfirst, cfirst);
    @(negedge clk); drive(lp, 0, 0);
    if (gap > 0) begin
      repeat (gap - 1) @(negedge clk);
      drive(lp, cfirst, !cfirst);
      @(negedge clk); drive(lp, 0, 0);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic lock_loop(input int lp);
    pulse_pair(lp, 0, 1);
    pulse_pair(lp, 1, 2);
    pulse_pair(lp, 0, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset unlocked", mon_o, 1'b0);
    save_rf = 1; repeat (2) @(negedge clk);
    check("R1 IF still unlocked", mon_o, 1'b0);
    save_if = 1; repeat (2) @(negedge clk);
    check("R6 both saved", mon_o, 1'b1);
  endtask

  task automatic t_streak();
    do_reset(); save_rf = 1;
    pulse_pair(0, 0, 1); pulse_pair(0, 1, 2);
    check("R4 two good not enough", mon_o, 1'b0);
    pulse_pair(0, 0, 0);
    check("R4 R2 third good locks", mon_o, 1'b1);
    pulse_pair(0, 1, 3);
    check("R5 middle width keeps lock", mon_o, 1'b1);
    pulse_pair(0, 0, 4);
    check("R3 width 4 unlocks", mon_o, 1'b0);
    pulse_pair(0, 0, 1); pulse_pair(0, 0, 1); pulse_pair(0, 1, 3);
    pulse_pair(0, 1, 1); pulse_pair(0, 0, 2);
    check("R5 middle width cleared run", mon_o, 1'b0);
    pulse_pair(0, 1, 0);
    check("R5 run rebuilt locks", mon_o, 1'b1);
    pulse_pair(0, 1, 20);
    check("R2 saturated long gap unlocks", mon_o, 1'b0);
  endtask

  task automatic t_slip();
    do_reset(); save_if = 1;
    lock_loop(1);
    check("R4 RF locks", mon_o, 1'b1);
    @(negedge clk); drive(1, 1, 0);
    @(negedge clk); drive(1, 0, 0);
    @(negedge clk); @(negedge clk); drive(1, 1, 0);
    @(negedge clk); drive(1, 0, 0);
    repeat (3) @(negedge clk);
    check("R8 repeated reference edge unlocks", mon_o, 1'b0);
  endtask

  task automatic t_combined();
    do_reset();
    lock_loop(0);
    check("R6 IF locked RF unlocked", mon_o, 1'b0);
    lock_loop(1);
    check("R6 both locked", mon_o, 1'b1);
    pulse_pair(1, 1, 10);
    check("R3 R6 RF unlock drops flag", mon_o, 1'b0);
    save_rf = 1; repeat (2) @(negedge clk);
    check("R6 RF save restores flag", mon_o, 1'b1);
    save_if = 1; pulse_pair(0, 0, 6);
    check("R6 IF unlocked but saved", mon_o, 1'b1);
    save_if = 0; repeat (2) @(negedge clk);
    check("R6 IF save released", mon_o, 1'b0);
  endtask

  task automatic t_mux();
    do_reset(); mon_en = 1;
    for (int src = 0; src < 4; src++) begin
      for (int sel = 0; sel < 4; sel++) begin
        @(negedge clk);
        ref_if = (src == 0); ref_rf = (src == 1);
        cmp_if = (src == 2); cmp_rf = (src == 3);
        tsel = 2'(sel);
        repeat (2) @(negedge clk);
        check("R7 monitor select", mon_o, sel == src);
      end
    end
    mon_en = 0; ref_if = 0; ref_rf = 0; cmp_if = 0; cmp_rf = 0;
    save_if = 1; save_rf = 1;
    repeat (2) @(negedge clk);
    check("R7 monitor off gives lock flag", mon_o, 1'b1);
  endtask

  task automatic t_latency();
    do_reset(); mon_en = 1; tsel = 2'b00;
    repeat (2) @(negedge clk);
    ref_if = 1; #1;
    check("R9 output not yet updated", mon_o, 1'b0);
    @(posedge clk); #1;
    check("R9 output one clock later", mon_o, 1'b1);
  endtask

  initial begin
    t_reset();
    t_streak();
    t_slip();
    t_combined();
    t_mux();
    t_latency();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule